// File: doc/BRIEF.md
# Phase-Programmable Pixel Data Output Stage

This block sits between the pixel converter and the output pads. It holds each converted sample for a fixed number of pixel periods, then drives it onto the parallel data output at a chosen sub-pixel position. It also produces the matching data clock. A free-running 6-bit position count divides every pixel period into 64 slots. A 13-bit control word selects the slot at which new data is launched and the slot that serves as the opposite clock edge. It also sets whether the clock follows the data slot or stays at a fixed slot.

A sample is captured whenever the sample strobe is high. Every clock edge at which the position count equals the launch slot is a launch edge, and each launch edge moves the captured samples one step along a delay line. The sample reaches the data output on the sixteenth launch edge after its strobe. The data clock comes from a small state machine with three states. Its transitions are:

- RESET_EXIT: IDLE goes to HIGH on the first rise slot.
- RISE: LOW goes to HIGH on the rise slot.
- FALL: HIGH goes to LOW on the fall slot.

Control word layout: bits [5:0] are the launch slot. Bits [11:6] are the companion slot, which is meant to be set to the launch slot plus 32, modulo 64. Bit 12 is the clock-mode bit, where 0 selects tracking and 1 selects fixed.

Top module: `dout_phase_stage`

## Requirements
- R1: While reset is low, `dout` is 0 and `dclk` is 0.
- R2: `dout` changes only at a clock edge where `phase_pos` equals `out_ctrl[5:0]`. At every other edge it holds its value.
- R3: A word presented on `adc_word` with `shd_strobe` high appears on `dout` at the 16th launch edge after that strobe.
- R4: When the strobe falls on a launch edge, that edge already carries the new word into the pipeline and counts as the first of the 16 launch edges.
- R5: Each launch edge loads the most recently captured word. With no strobe since the previous launch edge, the same word enters again.
- R6: After reset the pipeline holds zeros, so `dout` stays 0 through the first 15 launch edges.
- R7: With `out_ctrl[12]`=0, `dclk` goes high at the edge where `phase_pos` equals `out_ctrl[5:0]` and goes low at the edge where it equals `out_ctrl[11:6]`.
- R8: With `out_ctrl[12]`=1, `dclk` goes high at position 0 and low at position 32, whatever the two slot fields hold. Data still launches at `out_ctrl[5:0]`.
- R9: The companion field `out_ctrl[11:6]` has no effect on when or what `dout` updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, 64 cycles per pixel |
| rst_n | input | 1 | Active-low reset |
| phase_pos | input | 6 | Current position within the pixel period |
| shd_strobe | input | 1 | Capture strobe for `adc_word` |
| adc_word | input | 12 | Converted sample word |
| out_ctrl | input | 13 | [5:0] launch slot, [11:6] companion slot, [12] fixed-clock mode |
| dout | output | 12 | Launched pixel data |
| dclk | output | 1 | Data clock |

## Verification
Sample capture and the pipeline shift can fall in the same cycle, namely when the strobe arrives exactly at the launch slot. The bench provokes this by raising the strobe on the cycle whose position equals the launch slot. It then counts launch edges, with the coinciding edge counted as the first. The word must still read 0 after fifteen edges and must appear on the sixteenth. In tracking mode the `dclk` rise and the `dout` update also share an edge. Both are judged at that same sample point.

// File: rtl/dout_stage_pkg.sv
package dout_stage_pkg;

    localparam int PHASE_W = 6;
    localparam int PHASE_N = 1 << PHASE_W;
    localparam int CTRL_W  = 2 * PHASE_W + 1;

    typedef logic [PHASE_W-1:0] phase_t;

    // packed order gives bit 12 = mode, [11:6] = companion, [5:0] = launch
    typedef struct packed {
        logic   fixed_clk;
        phase_t comp;
        phase_t launch;
    } ctrl_t;

    typedef enum logic [1:0] {
        DCK_IDLE = 2'd0,
        DCK_HIGH = 2'd1,
        DCK_LOW  = 2'd2
    } dck_state_e;

endpackage

// File: rtl/dout_edge_decode.sv
module dout_edge_decode
    import dout_stage_pkg::*;
(
    input  ctrl_t  ctrl,
    input  phase_t phase,
    output logic   launch_hit,
    output logic   rise_hit,
    output logic   fall_hit
);

    localparam phase_t FIX_RISE = '0;
    localparam phase_t FIX_FALL = phase_t'(PHASE_N / 2);

    phase_t rise_pos;
    phase_t fall_pos;

    always_comb begin
        if (ctrl.fixed_clk) begin
            rise_pos = FIX_RISE;
            fall_pos = FIX_FALL;
        end else begin
            rise_pos = ctrl.launch;
            fall_pos = ctrl.comp;
        end
    end

    assign launch_hit = (phase == ctrl.launch);
    assign rise_hit   = (phase == rise_pos);
    assign fall_hit   = (phase == fall_pos);

endmodule

// File: rtl/dout_delay_line.sv
module dout_delay_line #(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] sample,
    input  logic              advance,
    output logic [DATA_W-1:0] word_out
);

    localparam int STAGES = LATENCY - 1;

    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] entry;

    // a strobe on the launch edge feeds the fresh word straight in
    assign entry = capture ? sample : held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= sample;
        end
    end

    generate
        if (STAGES > 0) begin : g_line
            logic [STAGES-1:0][DATA_W-1:0] stage;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage    <= '0;
                    word_out <= '0;
                end else if (advance) begin
                    stage[0] <= entry;
                    for (int i = 1; i < STAGES; i++) begin
                        stage[i] <= stage[i-1];
                    end
                    word_out <= stage[STAGES-1];
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_out <= '0;
                end else if (advance) begin
                    word_out <= entry;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dout_clk_fsm.sv
module dout_clk_fsm
    import dout_stage_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_hit,
    input  logic fall_hit,
    output logic dclk
);

    dck_state_e state;
    dck_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DCK_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DCK_IDLE: if (rise_hit) state_nx = DCK_HIGH;
            DCK_LOW:  if (rise_hit) state_nx = DCK_HIGH;
            DCK_HIGH: if (fall_hit) state_nx = DCK_LOW;
            default:  state_nx = DCK_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            DCK_HIGH: dclk = 1'b1;
            default:  dclk = 1'b0;
        endcase
    end

endmodule

// File: rtl/dout_phase_stage.sv
module dout_phase_stage #(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [dout_stage_pkg::PHASE_W-1:0]  phase_pos,
    input  logic                                shd_strobe,
    input  logic [DATA_W-1:0]                   adc_word,
    input  logic [dout_stage_pkg::CTRL_W-1:0]   out_ctrl,
    output logic [DATA_W-1:0]                   dout,
    output logic                                dclk
);

    import dout_stage_pkg::*;

    ctrl_t ctrl;
    logic  launch_hit;
    logic  rise_hit;
    logic  fall_hit;

    assign ctrl = ctrl_t'(out_ctrl);

    dout_edge_decode u_decode (
        .ctrl       (ctrl),
        .phase      (phase_pos),
        .launch_hit (launch_hit),
        .rise_hit   (rise_hit),
        .fall_hit   (fall_hit)
    );

    dout_delay_line #(
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (shd_strobe),
        .sample   (adc_word),
        .advance  (launch_hit),
        .word_out (dout)
    );

    dout_clk_fsm u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_hit (rise_hit),
        .fall_hit (fall_hit),
        .dclk     (dclk)
    );

endmodule

// File: rtl/dout_phase_stage_chk.sv
module dout_phase_stage_chk #(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [dout_stage_pkg::PHASE_W-1:0]  phase_pos,
    input logic [dout_stage_pkg::CTRL_W-1:0]   out_ctrl,
    input logic [DATA_W-1:0]                   dout,
    input logic                                dclk
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] seen_launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_launch <= '0;
        end else if (phase_pos == out_ctrl[5:0] && seen_launch < CNT_W'(LATENCY)) begin
            seen_launch <= seen_launch + 1'b1;
        end
    end

    a_r2_update_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(phase_pos) == $past(out_ctrl[5:0]));

    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_launch < CNT_W'(LATENCY)) |-> dout == '0);

    a_r7_track_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dclk) && !$past(out_ctrl[12])) |-> $past(phase_pos) == $past(out_ctrl[5:0]));

    a_r7_track_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dclk) && !$past(out_ctrl[12])) |-> $past(phase_pos) == $past(out_ctrl[11:6]));

    a_r8_fixed_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dclk) && $past(out_ctrl[12])) |-> $past(phase_pos) == 6'd0);

    a_r8_fixed_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dclk) && $past(out_ctrl[12])) |-> $past(phase_pos) == 6'd32);

endmodule

bind dout_phase_stage dout_phase_stage_chk #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_pos (phase_pos),
    .out_ctrl  (out_ctrl),
    .dout      (dout),
    .dclk      (dclk)
);

// File: tb/dout_phase_stage_test.sv
module dout_phase_stage_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  phase = 6'd0;
    logic        strobe = 1'b0;
    logic [11:0] word = 12'd0;
    logic [12:0] ctrl = 13'd0;
    logic [11:0] dout;
    logic        dclk;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    always @(negedge clk) phase <= phase + 6'd1;

    dout_phase_stage uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_pos  (phase),
        .shd_strobe (strobe),
        .adc_word   (word),
        .out_ctrl   (ctrl),
        .dout       (dout),
        .dclk       (dclk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_phase(input int p);
        while (phase != 6'(p)) step();
    endtask

    task automatic set_ctrl(input bit fixed, input int comp, input int launch);
        ctrl = {fixed, 6'(comp), 6'(launch)};
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        strobe = 1'b0;
        repeat (3) step();
        check(dout == 12'd0, "R1 dout", int'(dout), 0);
        check(dclk == 1'b0, "R1 dclk", int'(dclk), 0);
        rst_n = 1'b1;
    endtask

    // one strobe, then count launch edges until the word shows up
    task automatic t_latency(input int launch, input int comp, input bit coincide,
                             input logic [11:0] val, input string tag);
        int launches;
        logic [11:0] prev;
        logic [5:0]  p;
        set_ctrl(1'b0, comp, launch);
        do_reset();
        if (coincide) wait_phase(launch);
        else wait_phase((launch + 20) % 64);
        strobe = 1'b1;
        word   = val;
        step();
        strobe   = 1'b0;
        word     = 12'hFFF;
        launches = coincide ? 1 : 0;
        while (launches < 17) begin
            p    = phase;
            prev = dout;
            step();
            if (p == 6'(launch)) begin
                launches++;
                if (launches < 16)
                    check(dout == 12'd0, "R6 zero fill", int'(dout), 0);
                else
                    check(dout == val, tag, int'(dout), int'(val));
            end else begin
                check(dout == prev, (tag == "R9") ? "R9 hold" : "R2 hold", int'(dout), int'(prev));
            end
        end
    endtask

    task automatic t_repeat();
        int launches;
        logic [5:0] p;
        set_ctrl(1'b0, 42, 10);
        do_reset();
        wait_phase(20);
        strobe = 1'b1;
        word   = 12'h0A5;
        step();
        strobe   = 1'b0;
        launches = 0;
        while (launches < 18) begin
            p = phase;
            if (launches == 2 && p == 6'd20) begin
                strobe = 1'b1;
                word   = 12'h35B;
            end else begin
                strobe = 1'b0;
            end
            step();
            if (p == 6'd10) begin
                launches++;
                if (launches == 16 || launches == 17)
                    check(dout == 12'h0A5, "R5 repeat", int'(dout), 'h0A5);
                else if (launches == 18)
                    check(dout == 12'h35B, "R5 newest", int'(dout), 'h35B);
            end
        end
        strobe = 1'b0;
    endtask

    // one new word per pixel; judge dclk level and dout timing
    task automatic t_dclk(input bit fixed, input int launch, input int comp, input string tag);
        int rise;
        int fall;
        int launches;
        int cnt;
        bit lvl;
        bit known;
        logic [11:0] prev;
        logic [5:0]  p;
        rise = fixed ? 0 : launch;
        fall = fixed ? 32 : comp;
        set_ctrl(fixed, comp, launch);
        do_reset();
        launches = 0;
        cnt      = 1;
        known    = 1'b0;
        lvl      = 1'b0;
        repeat (20 * 64) begin
            p = phase;
            if (p == 6'((launch + 32) % 64)) begin
                strobe = 1'b1;
                word   = 12'(cnt);
                cnt++;
            end else begin
                strobe = 1'b0;
            end
            prev = dout;
            step();
            if (p == 6'(rise)) begin
                lvl = 1'b1;
                known = 1'b1;
            end else if (p == 6'(fall)) begin
                lvl = 1'b0;
                known = 1'b1;
            end
            if (known) check(dclk == lvl, tag, int'(dclk), int'(lvl));
            if (p == 6'(launch)) begin
                launches++;
                if (launches > 16)
                    check(dout != prev, "R8 data still launches", int'(dout), int'(prev) + 1);
            end else begin
                check(dout == prev, "R2 hold between launches", int'(dout), int'(prev));
            end
        end
        strobe = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_latency(10, 42, 1'b0, 12'h5C3, "R3 latency");
        t_latency(37, 5, 1'b1, 12'h9E1, "R4 coincident strobe");
        t_latency(10, 5, 1'b0, 12'h777, "R9");
        t_repeat();
        t_dclk(1'b0, 10, 42, "R7 tracking dclk");
        t_dclk(1'b1, 17, 49, "R8 fixed dclk");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule